// File: doc/BRIEF.md
# Strap-Addressed Serial Control Slave

This block is a two-wire serial bus slave (I2C-compatible, standard and fast mode up to 400 kHz) that sits beside an analog demodulator. A host uses it to load a small bank of control registers and to read back one status byte. SCL and SDA are sampled with the system clock, which must run at 16 or more times the SCL rate. START and STOP conditions are SDA edges seen while SCL is high.

Two strap inputs set two bits of the 7-bit slave address, so four of these slaves can share one bus. The two straps act with opposite polarity. Strap 0 also picks which of two preset register sets is loaded after reset, so the device can run with no host attached.

A write transfer carries a subaddress and then data bytes, and the register index advances after each data byte. A read transfer returns the status byte again for as long as the host acknowledges. The status byte holds a sticky power-on flag. Reset or a supply dropout sets it, and a completed read clears it.

Top module: `strap_i2c_slave`

## Requirements
- R1: The slave address is {1,0,0,A3,0,1,A0}, with A3 = strap1_i and A0 = NOT strap0_i. This gives 43h, 42h, 4Bh or 4Ah. On a matching address byte (bit 0 = 0 for write, 1 for read), the slave pulls SDA low in the 9th clock.
- R2: After an address byte that does not match, the slave never drives SDA and changes no register until the next START.
- R3: In a write transfer, the first byte after the address is the register index. Each later data byte is acknowledged and stored at that index, then the index rises by one. Register k appears on regs_o[8k+7:8k].
- R4: A data byte aimed at an index of NUM_REGS (3) or more is acknowledged and discarded.
- R5: The read byte is sent MSB first. It is {afc_win_i, vif_lev_i, carr_det_i, afc_i[3:0], por} and is captured when its first bit is put on the bus.
- R6: While the host acknowledges, the slave sends a fresh status byte. After a not-acknowledge it releases SDA and waits for START.
- R7: The por flag is 1 after reset. It is cleared when the acknowledge bit of a sent status byte has been sampled. A high supply_fail_i sets it, and this set wins over a clear in the same cycle.
- R8: After reset the registers take 16h, D6h, 30h (indexes 0..2) when strap0_i is low, and 56h, D6h, 30h when it is high.
- R9: A STOP releases SDA and ends the transfer. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap0_i | input | 1 | Address strap for A0 (inverted), also selects the preset |
| strap1_i | input | 1 | Address strap for A3 |
| afc_win_i | input | 1 | VCO inside the AFC window |
| vif_lev_i | input | 1 | Input level high |
| carr_det_i | input | 1 | FM carrier detected |
| afc_i | input | 4 | AFC value |
| supply_fail_i | input | 1 | Supply dropout, sets the power-on flag |
| regs_o | output | NUM_REGS*8 | Control register contents |

## Verification
Two events can land in the same cycle: a supply dropout setting the power-on flag, and the acknowledge sample of a status byte clearing it. The bench makes them meet by holding supply_fail_i high for the whole acknowledge clock pulse of a read. It judges the outcome by the next read, which must still show the flag as 1. A second read after that must show it as 0. Alongside this, random writes with indexes that run past the register bank, and reads with random status fields, are checked against a bench register model.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK
  } bus_state_e;

  localparam logic [2:0] ADDR_HI  = 3'b100;
  localparam logic [1:0] ADDR_MID = 2'b01;

  function automatic logic [6:0] make_addr(input logic strap0, input logic strap1);
    return {ADDR_HI, strap1, ADDR_MID, ~strap0};
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[SYNC_STAGES-1];
  assign sda_s      = sda_pipe[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges with SCL held high are bus conditions
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import strap_i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       status_ack_o
);
  localparam logic [3:0] BITS = 4'd8;

  bus_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, ptr_q, wr_idx_q, wr_data_q;
  logic       sub_pend_q, rd_dir_q, rd_more_q, wr_en_q, ack_smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ptr_q      <= '0;
      sub_pend_q <= 1'b0;
      rd_dir_q   <= 1'b0;
      rd_more_q  <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_idx_q   <= '0;
      wr_data_q  <= '0;
      ack_smp_q  <= 1'b0;
    end else begin
      wr_en_q   <= 1'b0;
      ack_smp_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise_i && cnt_q < BITS) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == BITS) begin
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == dev_addr_i) begin
                  state_q  <= ST_ADDR_ACK;
                  rd_dir_q <= sh_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q <= ST_WR_ACK;
                if (sub_pend_q) begin
                  ptr_q      <= sh_q;
                  sub_pend_q <= 1'b0;
                end else begin
                  wr_en_q   <= 1'b1;
                  wr_idx_q  <= ptr_q;
                  wr_data_q <= sh_q;
                  ptr_q     <= ptr_q + 8'd1;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rd_dir_q) begin
                state_q <= ST_RD_BYTE;
                sh_q    <= status_i;
              end else begin
                state_q    <= ST_WR_BYTE;
                sub_pend_q <= 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              state_q <= ST_WR_BYTE;
              cnt_q   <= '0;
            end
          end
          ST_RD_BYTE: begin
            if (scl_rise_i && cnt_q < BITS) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == BITS) state_q <= ST_RD_ACK;
              else               sh_q    <= {sh_q[6:0], 1'b0};
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              ack_smp_q <= 1'b1;
              rd_more_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (rd_more_q) begin
                state_q <= ST_RD_BYTE;
                sh_q    <= status_i;
                cnt_q   <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o     = (state_q == ST_ADDR_ACK) | (state_q == ST_WR_ACK) |
                        ((state_q == ST_RD_BYTE) & ~sh_q[7]);
  assign wr_en_o      = wr_en_q;
  assign wr_idx_o     = wr_idx_q;
  assign wr_data_o    = wr_data_q;
  assign status_ack_o = ack_smp_q;

  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !sda_oe_o);
  p_start_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_q == ST_ADDR);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && !start_i |=> !sda_oe_o);
  p_write_in_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> state_q == ST_WR_ACK);
  p_ack_after_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_ack_o |-> state_q == ST_RD_ACK);
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int                    NUM_REGS  = 3,
  parameter logic [NUM_REGS*8-1:0] DEF_OPEN  = 24'h30D616,
  parameter logic [NUM_REGS*8-1:0] DEF_STRAP = 24'h30D656
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strap0_i,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_idx_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic init_q;

  // preset is picked on the first clock after reset, strap sampled then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b0;
    else         init_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 val_q <= DEF_OPEN[g*8 +: 8];
      else if (!init_q)                            val_q <= strap0_i ? DEF_STRAP[g*8 +: 8]
                                                                     : DEF_OPEN[g*8 +: 8];
      else if (wr_en_i && wr_idx_i == 8'(g))       val_q <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = val_q;
  end

  p_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> regs_o == ($past(strap0_i) ? DEF_STRAP : DEF_OPEN));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q && !wr_en_i |=> $stable(regs_o));
  p_discard_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q && wr_en_i && wr_idx_i >= 8'(NUM_REGS) |=> $stable(regs_o));
endmodule

// File: rtl/status_flags.sv
module status_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       afc_win_i,
  input  logic       vif_lev_i,
  input  logic       carr_det_i,
  input  logic [3:0] afc_i,
  input  logic       supply_fail_i,
  input  logic       status_ack_i,
  output logic [7:0] status_o
);
  logic por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            por_q <= 1'b1;
    else if (supply_fail_i) por_q <= 1'b1;
    else if (status_ack_i)  por_q <= 1'b0;
  end

  assign status_o = {afc_win_i, vif_lev_i, carr_det_i, afc_i, por_q};

  p_por_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_fail_i |=> por_q);
  p_por_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_ack_i && !supply_fail_i |=> !por_q);
  p_por_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_q && !status_ack_i |=> por_q);
endmodule

// File: rtl/strap_i2c_slave.sv
module strap_i2c_slave
  import strap_i2c_pkg::*;
#(
  parameter int                    NUM_REGS    = 3,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] DEF_OPEN    = 24'h30D616,
  parameter logic [NUM_REGS*8-1:0] DEF_STRAP   = 24'h30D656
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  strap0_i,
  input  logic                  strap1_i,
  input  logic                  afc_win_i,
  input  logic                  vif_lev_i,
  input  logic                  carr_det_i,
  input  logic [3:0]            afc_i,
  input  logic                  supply_fail_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic       wr_en, status_ack;
  logic [7:0] wr_idx, wr_data, status;
  logic [6:0] dev_addr;

  assign dev_addr = make_addr(strap0_i, strap1_i);

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  i2c_byte_engine u_engine (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .sda_i(sda_s),
    .dev_addr_i(dev_addr), .status_i(status),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .status_ack_o(status_ack)
  );

  ctrl_regfile #(.NUM_REGS(NUM_REGS), .DEF_OPEN(DEF_OPEN), .DEF_STRAP(DEF_STRAP)) u_regs (
    .clk_i, .rst_ni, .strap0_i,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .regs_o
  );

  status_flags u_status (
    .clk_i, .rst_ni, .afc_win_i, .vif_lev_i, .carr_det_i, .afc_i,
    .supply_fail_i, .status_ack_i(status_ack), .status_o(status)
  );
endmodule

// File: tb/strap_i2c_slave_tb.sv
module strap_i2c_slave_tb;
  localparam logic [23:0] DEF_OPEN_TB  = 24'h30D616;
  localparam logic [23:0] DEF_STRAP_TB = 24'h30D656;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic strap0 = 1'b0, strap1 = 1'b0;
  logic win = 1'b0, lev = 1'b0, car = 1'b0, sfail = 1'b0;
  logic [3:0] afc = 4'h0;
  logic sda_oe, sda_line;
  logic [23:0] regs;
  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] mreg [3];
  bit mpor = 1'b1;
  bit quiet_watch = 1'b0, quiet_bad = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  strap_i2c_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap0_i(strap0), .strap1_i(strap1), .afc_win_i(win), .vif_lev_i(lev),
    .carr_det_i(car), .afc_i(afc), .supply_fail_i(sfail), .regs_o(regs)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<190000", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) if (quiet_watch && sda_oe) quiet_bad = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_addr(input logic s0, input logic s1);
    return {3'b100, s1, 2'b01, ~s0};
  endfunction

  function automatic logic [7:0] exp_status();
    return {win, lev, car, afc, mpor};
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit more);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~more);
  endtask

  task automatic regs_chk(input string tag);
    chk(tag, {8'h0, regs}, {8'h0, mreg[2], mreg[1], mreg[0]});
  endtask

  task automatic do_write(input logic [7:0] sub, input int n, input logic [23:0] dat,
                          input string tag);
    bit ack;
    i2c_start();
    put_byte({exp_addr(strap0, strap1), 1'b0}, ack); chk({tag, " addr ack"}, ack, 1);
    put_byte(sub, ack); chk({tag, " sub ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(dat[i*8 +: 8], ack); chk({tag, " data ack"}, ack, 1);
      if (int'(sub) + i < 3) mreg[int'(sub) + i] = dat[i*8 +: 8];
    end
    i2c_stop();
  endtask

  task automatic do_read1(input string tag);
    bit ack;
    logic [7:0] b;
    i2c_start();
    put_byte({exp_addr(strap0, strap1), 1'b1}, ack); chk({tag, " rd addr ack"}, ack, 1);
    get_byte(b, 1'b0);
    chk({tag, " status"}, b, exp_status());
    mpor = 1'b0;
    i2c_stop();
  endtask

  task automatic load_model(input logic [23:0] v);
    mreg[0] = v[7:0]; mreg[1] = v[15:8]; mreg[2] = v[23:16];
  endtask

  initial begin
    bit ack;
    logic [7:0] b, b2;
    void'($urandom(32'd2024));
    load_model(DEF_OPEN_TB);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R8 preset with strap0 low, reset state
    regs_chk("R8 open preset");
    chk("R9 reset sda released", sda_oe, 0);

    // R5 / R7: first read shows por=1, then 0
    win = 1; lev = 0; car = 1; afc = 4'hA;
    do_read1("R7 first read");
    win = 0; lev = 1; car = 0; afc = 4'h5;
    do_read1("R7 second read");

    // R6: two bytes, status changes after the first is captured
    win = 1; lev = 1; car = 1; afc = 4'h3;
    i2c_start();
    put_byte({exp_addr(strap0, strap1), 1'b1}, ack); chk("R6 addr ack", ack, 1);
    b2 = exp_status();
    win = 0; lev = 0; car = 1; afc = 4'hC;
    get_byte(b, 1'b1);
    chk("R5 byte1 snapshot", b, b2);
    get_byte(b, 1'b0);
    chk("R6 byte2 fresh", b, exp_status());
    repeat (8) @(negedge clk);
    chk("R6 released after nack", sda_oe, 0);
    i2c_stop();

    // R1: every strap pair against every candidate address
    for (int s = 0; s < 4; s++) begin
      strap0 = s[0]; strap1 = s[1];
      for (int c = 0; c < 4; c++) begin
        logic [6:0] cand;
        cand = exp_addr(c[0], c[1]);
        i2c_start();
        put_byte({cand, 1'b0}, ack);
        chk("R1 address match", ack, (c == s) ? 1 : 0);
        i2c_stop();
      end
    end
    strap0 = 0; strap1 = 0;

    // R2: foreign address followed by would-be data
    quiet_bad = 0; quiet_watch = 1;
    i2c_start();
    put_byte(8'h88, ack); chk("R2 foreign addr nack", ack, 0);
    put_byte(8'h00, ack); chk("R2 sub ignored", ack, 0);
    put_byte(8'hAA, ack); chk("R2 data ignored", ack, 0);
    i2c_stop();
    quiet_watch = 0;
    chk("R2 sda never driven", quiet_bad, 0);
    regs_chk("R2 regs unchanged");

    // R3 auto-increment, R4 overflow discard
    do_write(8'd0, 3, 24'h33_22_11, "R3");
    regs_chk("R3 three bytes");
    do_write(8'd2, 3, 24'hC3_B2_A1, "R4");
    regs_chk("R4 tail discarded");
    do_write(8'd7, 1, 24'h0000EE, "R4 oob");
    regs_chk("R4 out of range");

    // R9 repeated START from write into read
    i2c_start();
    put_byte({exp_addr(strap0, strap1), 1'b0}, ack); chk("R9 wr addr", ack, 1);
    put_byte(8'd1, ack); chk("R9 sub", ack, 1);
    put_byte(8'h5A, ack); chk("R9 data", ack, 1);
    mreg[1] = 8'h5A;
    i2c_start();
    put_byte({exp_addr(strap0, strap1), 1'b1}, ack); chk("R9 restart ack", ack, 1);
    get_byte(b, 1'b0);
    chk("R9 status after restart", b, exp_status());
    mpor = 0;
    i2c_stop();
    regs_chk("R9 reg written before restart");

    // R7 collision: dropout held across the acknowledge clock of a read
    i2c_start();
    put_byte({exp_addr(strap0, strap1), 1'b1}, ack); chk("R7 coll addr", ack, 1);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    chk("R7 coll byte", b, exp_status());
    sfail = 1'b1;
    put_bit(1'b1);
    sfail = 1'b0;
    i2c_stop();
    mpor = 1'b1;
    do_read1("R7 set wins over clear");
    do_read1("R7 cleared afterwards");
    @(negedge clk); sfail = 1'b1; @(negedge clk); sfail = 1'b0;
    mpor = 1'b1;
    do_read1("R7 dropout while idle");

    // random mix of writes and reads
    for (int k = 0; k < 30; k++) begin
      if ($urandom_range(0, 2) != 0) begin
        logic [7:0] sub;
        int n;
        sub = 8'($urandom_range(0, 4));
        n = $urandom_range(1, 3);
        do_write(sub, n, 24'($urandom()), "R3 rand");
        regs_chk("R3 R4 rand model");
      end else begin
        {win, lev, car, afc} = 7'($urandom());
        do_read1("R5 rand");
      end
    end

    // R8 preset with strap0 high
    rst_n = 1'b0; strap0 = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    load_model(DEF_STRAP_TB);
    mpor = 1'b1;
    regs_chk("R8 strap preset");
    do_read1("R7 por after reset");

    summary();
    $finish;
  end
endmodule